// File: doc/BRIEF.md
# Interrupt Source Collector

This block gathers every interrupt source of a small 8-bit processor core into one request line and one wake-up line. It watches an external pin for an edge of programmable polarity, takes a counter overflow pulse, compares a group of port pins against a snapshot taken at the last port read, and receives one-cycle event pulses from a set of peripherals. Each source has a sticky flag and an enable bit. Software reaches both through a small byte-wide register port.

The request to the core is the OR of the enabled core-level sources and the peripheral group. The peripheral group has its own group enable. A global enable then gates the result. While the core sleeps, any enabled source with its flag set raises the wake-up line, whatever the global enable. After the core wakes, it branches to the handler only if the request is asserted. The block signals that branch with a one-cycle vector pulse at an instruction boundary.

The register map places control at address 0, core flags at 1, the change mask at 2, peripheral enables at 3 and 4, and peripheral flags at 5 and 6. Peripheral bit i sits in byte i/8 of its pair, at bit i%8.

Top module: `intr_collect`

## Requirements
- R1: The external pin is synchronized through two flops. It sets the external flag (core flag bit 0) on a rising edge when control bit 5 is 1, and on a falling edge when control bit 5 is 0. An edge of the other polarity leaves the flag clear.
- R2: Each flag stays set until a register write puts 0 in its bit. A write of 0 clears it.
- R3: A pulse on the overflow input sets the timer flag (core flag bit 1).
- R4: The change flag (core flag bit 2) is set while a synchronized pin whose mask bit (address 2) is 1 differs from the value latched at the last port read. Pins whose mask bit is 0 never set it.
- R5: A pin marked analog reads as 0, so toggling it never sets the change flag.
- R6: Each port read reloads the latch from the current pins. A change seen in the same cycle as a read still sets the flag. After the read, the flag can be cleared and stays clear.
- R7: Each peripheral flag is set by its event pulse. It contributes only when its own enable bit is set and the group enable (control bit 1) is set.
- R8: The request equals global enable (control bit 0) AND the OR of the terms external (control bit 2), timer (bit 3), change (bit 4) and peripheral group, each term being its enable AND its flag.
- R9: While the sleep input is high, wake-up is asserted when any enabled source has its flag set, even with the global enable at 0. Wake-up is low when the sleep input is low.
- R10: When a flag is cleared by a write in the same cycle that a hardware event for it arrives, the flag ends up set.
- R11: When the request and the boundary input are both high, the vector output pulses high for exactly one cycle, one clock later. It does not pulse while the request is low.
- R12: After reset, every register reads 0 and the request, wake-up and vector outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | External interrupt pin |
| port_pins_i | input | NPORT | Port pins watched for change |
| analog_i | input | NPORT | Per-pin analog select; an analog pin reads 0 |
| port_rd_i | input | 1 | Core reads the port this cycle |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| per_evt_i | input | NPER | Peripheral event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| sleep_i | input | 1 | Core is in sleep |
| boundary_i | input | 1 | Core is at an instruction boundary |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-up from sleep |
| vector_o | output | 1 | One-cycle branch-to-handler pulse |

## Verification
The bench uses the defaults NPORT=6 and NPER=9. With NPER=9 the last peripheral falls into the upper byte of both the enable and the flag pairs. The table therefore reaches the bank split as well as the group and global gating. Six port pins leave room for one masked pin, one analog pin and one live pin, each driven separately. A read-and-change collision is also placed exactly on the cycle where the synchronized value first moves.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PFLAG = 3'd5;

  typedef struct packed {
    logic ext_rise;
    logic chg_en;
    logic tmr_en;
    logic ext_en;
    logic per_en;
    logic glb_en;
  } ctrl_t;

  typedef struct packed {
    logic chg_f;
    logic tmr_f;
    logic ext_f;
  } cflag_t;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intr_port_chg.sv
module intr_port_chg #(
  parameter int unsigned NPORT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] pins_i,
  input  logic [NPORT-1:0] analog_i,
  input  logic [NPORT-1:0] mask_i,
  input  logic             rd_i,
  output logic             chg_evt_o
);
  logic [NPORT-1:0] pins_s, pins_eff, snap_q;

  intr_sync #(.W(NPORT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  assign pins_eff = pins_s & ~analog_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (rd_i) snap_q <= pins_eff;
  end

  // compared against the old snapshot, so a change during a read is kept
  assign chg_evt_o = |((pins_eff ^ snap_q) & mask_i);

  // R4
  chg_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_evt_o |-> |mask_i);
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int unsigned NPORT = 6,
  parameter int unsigned NPER  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_evt_i,
  input  logic              tmr_evt_i,
  input  logic              chg_evt_i,
  input  logic [NPER-1:0]   per_evt_i,
  output ctrl_t             ctrl_o,
  output cflag_t            cflag_o,
  output logic [NPORT-1:0]  mask_o,
  output logic [NPER-1:0]   pen_o,
  output logic [NPER-1:0]   pflag_o
);
  localparam int unsigned CW = $bits(ctrl_t);
  localparam int unsigned FW = $bits(cflag_t);

  ctrl_t            ctrl_q;
  cflag_t           cflag_q;
  logic [NPORT-1:0] mask_q;
  logic [NPER-1:0]  pen_q, pflag_q;

  logic wr_ctrl, wr_cflag, wr_mask;
  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign wr_cflag = we_i && (addr_i == A_CFLAG);
  assign wr_mask  = we_i && (addr_i == A_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cflag_q <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CW-1:0]);
      if (wr_mask) mask_q <= wdata_i[NPORT-1:0];
      // hardware events win over a same-cycle clear
      cflag_q.ext_f <= (wr_cflag ? wdata_i[0] : cflag_q.ext_f) | ext_evt_i;
      cflag_q.tmr_f <= (wr_cflag ? wdata_i[1] : cflag_q.tmr_f) | tmr_evt_i;
      cflag_q.chg_f <= (wr_cflag ? wdata_i[2] : cflag_q.chg_f) | chg_evt_i;
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_per
    localparam logic [ADDR_W-1:0] PEN_A = A_PEN   + ADDR_W'(i / 8);
    localparam logic [ADDR_W-1:0] PFL_A = A_PFLAG + ADDR_W'(i / 8);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pen_q[i]   <= 1'b0;
        pflag_q[i] <= 1'b0;
      end else begin
        if (we_i && addr_i == PEN_A) pen_q[i] <= wdata_i[i % 8];
        pflag_q[i] <= ((we_i && addr_i == PFL_A) ? wdata_i[i % 8] : pflag_q[i])
                      | per_evt_i[i];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[CW-1:0]    = ctrl_q;
      A_CFLAG: rdata_o[FW-1:0]    = cflag_q;
      A_MASK:  rdata_o[NPORT-1:0] = mask_q;
      default: begin
        for (int i = 0; i < NPER; i++) begin
          if (addr_i == A_PEN   + ADDR_W'(i / 8)) rdata_o[i % 8] = pen_q[i];
          if (addr_i == A_PFLAG + ADDR_W'(i / 8)) rdata_o[i % 8] = pflag_q[i];
        end
      end
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign cflag_o = cflag_q;
  assign mask_o  = mask_q;
  assign pen_o   = pen_q;
  assign pflag_o = pflag_q;

  // R2
  ext_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cflag_q.ext_f && !wr_cflag) |=> cflag_q.ext_f);
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cflag && tmr_evt_i) |=> cflag_q.tmr_f);
  // R3
  tmr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i |=> cflag_q.tmr_f);
endmodule

// File: rtl/intr_combine.sv
module intr_combine
  import intr_pkg::*;
#(
  parameter int unsigned NPER = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctrl_t           ctrl_i,
  input  cflag_t          cflag_i,
  input  logic [NPER-1:0] pen_i,
  input  logic [NPER-1:0] pflag_i,
  input  logic            sleep_i,
  input  logic            boundary_i,
  output logic            irq_o,
  output logic            wake_o,
  output logic            vector_o
);
  logic per_any, pending, vec_q;

  assign per_any = ctrl_i.per_en & |(pen_i & pflag_i);
  assign pending = (ctrl_i.ext_en & cflag_i.ext_f)
                 | (ctrl_i.tmr_en & cflag_i.tmr_f)
                 | (ctrl_i.chg_en & cflag_i.chg_f)
                 | per_any;

  assign irq_o  = ctrl_i.glb_en & pending;
  assign wake_o = sleep_i & pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= 1'b0;
    else         vec_q <= irq_o & boundary_i & ~vec_q;
  end
  assign vector_o = vec_q;

  // R11
  vector_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_q |=> !vec_q);
  // R9
  wake_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && irq_o) |-> wake_o);
  // R11
  vector_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_q |-> $past(irq_o && boundary_i));
endmodule

// File: rtl/intr_collect.sv
module intr_collect
  import intr_pkg::*;
#(
  parameter int unsigned NPORT = 6,
  parameter int unsigned NPER  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic [NPORT-1:0]  port_pins_i,
  input  logic [NPORT-1:0]  analog_i,
  input  logic              port_rd_i,
  input  logic              tmr_ovf_i,
  input  logic [NPER-1:0]   per_evt_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              sleep_i,
  input  logic              boundary_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              vector_o
);
  ctrl_t            ctrl;
  cflag_t           cflag;
  logic [NPORT-1:0] mask;
  logic [NPER-1:0]  pen, pflag;
  logic             ext_s, ext_prev_q, ext_evt, chg_evt;

  intr_sync #(.W(1)) u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_pin_i),
    .q_o   (ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b0;
    else         ext_prev_q <= ext_s;
  end

  assign ext_evt = ctrl.ext_rise ? (ext_s & ~ext_prev_q) : (~ext_s & ext_prev_q);

  intr_port_chg #(.NPORT(NPORT)) u_chg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (port_pins_i),
    .analog_i (analog_i),
    .mask_i   (mask),
    .rd_i     (port_rd_i),
    .chg_evt_o(chg_evt)
  );

  intr_regs #(.NPORT(NPORT), .NPER(NPER)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .ext_evt_i(ext_evt),
    .tmr_evt_i(tmr_ovf_i),
    .chg_evt_i(chg_evt),
    .per_evt_i(per_evt_i),
    .ctrl_o   (ctrl),
    .cflag_o  (cflag),
    .mask_o   (mask),
    .pen_o    (pen),
    .pflag_o  (pflag)
  );

  intr_combine #(.NPER(NPER)) u_comb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .cflag_i   (cflag),
    .pen_i     (pen),
    .pflag_i   (pflag),
    .sleep_i   (sleep_i),
    .boundary_i(boundary_i),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .vector_o  (vector_o)
  );

  // R1
  ext_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_evt && !(reg_we_i && reg_addr_i == A_CFLAG)) |=> cflag.ext_f);
  // R9
  wake_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> !wake_o);
endmodule

// File: tb/intr_collect_tb.sv
module intr_collect_tb;
  localparam int NPORT = 6;
  localparam int NPER  = 9;
  localparam logic [7:0] GLB = 8'h01, PER = 8'h02, EXT = 8'h04, TMR = 8'h08,
                         CHG = 8'h10, RISE = 8'h20;

  // {ctrl[8], pen[9], evt[9], sleep, exp_irq, exp_wake}
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {8'h03, 9'h001, 9'h001, 1'b0, 1'b1, 1'b0},
    {8'h02, 9'h001, 9'h001, 1'b1, 1'b0, 1'b1},
    {8'h01, 9'h001, 9'h001, 1'b1, 1'b0, 1'b0},
    {8'h03, 9'h008, 9'h004, 1'b1, 1'b0, 1'b0},
    {8'h03, 9'h100, 9'h100, 1'b1, 1'b1, 1'b1},
    {8'h03, 9'h000, 9'h1FF, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_pin = 1'b0, port_rd = 1'b0, tmr_ovf = 1'b0, we = 1'b0;
  logic sleep = 1'b0, bnd = 1'b0;
  logic [NPORT-1:0] pins = '0, analog = '0;
  logic [NPER-1:0] evt = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, wake, vec;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_collect #(.NPORT(NPORT), .NPER(NPER)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .port_pins_i(pins),
    .analog_i(analog), .port_rd_i(port_rd), .tmr_ovf_i(tmr_ovf),
    .per_evt_i(evt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sleep_i(sleep), .boundary_i(bnd), .irq_o(irq),
    .wake_o(wake), .vector_o(vec)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_all();
    wr(3'd1, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
  endtask

  initial begin
    logic [7:0] r;
    cyc(2);
    // R12: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), r);
      chk("R12", r, 8'h00);
    end
    chk("R12", {5'b0, irq, wake, vec}, 8'h00);
    rst_n = 1'b1;
    cyc(2);

    // table: peripheral, group and global gating, wake
    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      clear_all();
      wr(3'd0, e[28:21]);
      wr(3'd3, {7'b0, e[20:12]} >> 0);
      wr(3'd4, {7'b0, e[20]});
      sleep = e[2];
      evt = e[11:3];
      cyc(1);
      evt = '0;
      cyc(1);
      chk("R7", {7'b0, irq}, {7'b0, e[1]});
      chk("R9", {7'b0, wake}, {7'b0, e[0]});
      sleep = 1'b0;
    end
    clear_all();
    rd(3'd6, r);
    chk("R2", r, 8'h00);

    // R1: rising edge with rise select
    wr(3'd0, GLB | EXT | RISE);
    ext_pin = 1'b1; cyc(4);
    rd(3'd1, r); chk("R1", r & 8'h01, 8'h01);
    chk("R8", {7'b0, irq}, 8'h01);
    // R11: vector pulse
    bnd = 1'b1; cyc(1);
    chk("R11", {7'b0, vec}, 8'h01);
    cyc(1);
    chk("R11", {7'b0, vec}, 8'h00);
    bnd = 1'b0;
    // R2: stays set, then clears
    cyc(3);
    rd(3'd1, r); chk("R2", r & 8'h01, 8'h01);
    wr(3'd1, 8'h00);
    rd(3'd1, r); chk("R2", r & 8'h01, 8'h00);
    // R1: falling edge ignored under rise select
    ext_pin = 1'b0; cyc(4);
    rd(3'd1, r); chk("R1", r & 8'h01, 8'h00);
    chk("R8", {7'b0, irq}, 8'h00);
    // R11: no pulse without request
    bnd = 1'b1; cyc(2);
    chk("R11", {7'b0, vec}, 8'h00);
    bnd = 1'b0;
    // R1: falling select
    wr(3'd0, GLB | EXT);
    ext_pin = 1'b1; cyc(4);
    rd(3'd1, r); chk("R1", r & 8'h01, 8'h00);
    ext_pin = 1'b0; cyc(4);
    rd(3'd1, r); chk("R1", r & 8'h01, 8'h01);
    wr(3'd1, 8'h00);

    // R3 / R8 timer
    wr(3'd0, TMR);
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    rd(3'd1, r); chk("R3", r & 8'h02, 8'h02);
    chk("R8", {7'b0, irq}, 8'h00);
    sleep = 1'b1; #1;
    chk("R9", {7'b0, wake}, 8'h01);
    sleep = 1'b0;
    // R10: clear and event same cycle
    we = 1'b1; addr = 3'd1; wdata = 8'h00; tmr_ovf = 1'b1;
    cyc(1);
    we = 1'b0; tmr_ovf = 1'b0;
    rd(3'd1, r); chk("R10", r & 8'h02, 8'h02);
    wr(3'd1, 8'h00);
    rd(3'd1, r); chk("R2", r & 8'h02, 8'h00);

    // port change: mask pins 0,1; pin 1 analog
    wr(3'd0, GLB | CHG);
    wr(3'd2, 8'h03);
    analog = 6'b000010;
    port_rd = 1'b1; cyc(1); port_rd = 1'b0;
    wr(3'd1, 8'h00);
    pins[2] = 1'b1; cyc(4);
    rd(3'd1, r); chk("R4", r & 8'h04, 8'h00);
    pins[1] = 1'b1; cyc(4);
    rd(3'd1, r); chk("R5", r & 8'h04, 8'h00);
    // R6: read collides with first cycle of change
    pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    port_rd = 1'b1; cyc(1); port_rd = 1'b0;
    rd(3'd1, r); chk("R6", r & 8'h04, 8'h04);
    chk("R8", {7'b0, irq}, 8'h01);
    wr(3'd1, 8'h00); cyc(2);
    rd(3'd1, r); chk("R6", r & 8'h04, 8'h00);
    // R4: unmasked pin drop sets flag
    pins[0] = 1'b0; cyc(4);
    rd(3'd1, r); chk("R4", r & 8'h04, 8'h04);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule